// File: doc/BRIEF.md
# Flash Page Write-Buffer Loader

This block sits behind the command decoder of a NOR flash controller and collects a buffered program operation. The host issues a load command at the lowest word address it intends to program. It then writes the word count minus one, the data words in strictly ascending address order, and a confirm code. Words are held in a page-wide buffer: 32 words by default, one page. Every data address must lie in the page of the starting address. The count and confirm writes must stay within its sector.

When the confirm arrives, the block raises a one-cycle program request. The request carries the page address, the buffered words and a mask marking which words of the page were actually loaded. A malformed sequence raises a sticky abort flag, and from then on all writes are ignored until reset. The array programming itself, unlock cycles and suspend handling belong to other blocks.

The load command is recognised on the low byte of a write, `0x3C` by default. The confirm code is the low byte `0xC3` by default. Both codes, the page depth, the sector size, the data and address widths, and whether gaps are allowed between loaded words are parameters.

Top module: `flash_wrbuf_loader`

## Requirements
- R1: After reset `prog_req` is 0, `load_abort` is 0 and `prog_mask` is all zeros.
- R2: A sequence is made of four parts, in this order. First, a load write (low data byte `0x3C`) at the starting address S. Next, a count write whose data holds N-1, with 0 ≤ N-1 ≤ 31. Then N data writes. Last, a confirm write (low data byte `0xC3`). In the clock cycle after the confirm edge this sequence produces `prog_req` high for exactly one cycle. At that point `prog_page` equals S[23:5], and word k of `prog_data` (bits 16k+15..16k) holds the data written to page offset k.
- R3: During the request, bit k of `prog_mask` is 1 exactly when a data word was written at page offset k. Words of the page that were not written read as zero. With the default gap option, ascending addresses that skip offsets are accepted.
- R4: S need not be the page base. The first data write must be at address S itself, or the load aborts.
- R5: Each data address after the first must have a page offset strictly greater than the previous one. An equal or lower offset aborts the load.
- R6: A data write whose address bits [23:5] differ from those of S aborts the load. So does a count or confirm write whose address bits [23:16] differ from those of S.
- R7: A count value above 31 aborts the load.
- R8: The write that follows the N-th data word must carry the confirm code. Any other value aborts the load, and no request is issued.
- R9: An abort sets `load_abort` in the cycle after the offending write. The flag stays set and every later write is ignored, so no `prog_req` appears until reset.
- R10: In the idle state, writes whose low byte is not the load code have no effect: no request, no abort, and a following valid sequence completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 24 | Word address of the write |
| wr_data | input | 16 | Write data (command, count, confirm or data word) |
| prog_req | output | 1 | One-cycle program request |
| prog_page | output | 19 | Page address of the request |
| prog_mask | output | 32 | Per-word program mask of the request |
| prog_data | output | 512 | Buffered page, word k at bits 16k+15..16k |
| load_abort | output | 1 | Sticky abort flag |

## Verification
Each write is accepted on one rising edge. Both results that a write can cause are registered once: `prog_req` after a confirm, and `load_abort` after an offending write. Both therefore show in the cycle that directly follows that edge. The bench drives each write one time unit after a rising edge, waits for the next edge, and samples the outputs one time unit later. Every check thus reads the response to exactly the write just made, away from any edge. The request is also sampled one cycle later to confirm that it is a single-cycle pulse.

// File: rtl/wbl_pkg.sv
package wbl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_COUNT   = 3'd1,
      ST_DATA    = 3'd2,
      ST_CONFIRM = 3'd3,
      ST_ABORT   = 3'd4
   } wbl_state_e;
endpackage

// File: rtl/wbl_addr_check.sv
module wbl_addr_check #(
   parameter int ADDR_W   = 24,
   parameter int OFF_W    = 5,
   parameter int SECT_LSB = 16,
   parameter bit GAPS_OK  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [OFF_W-1:0]  last_off,
   input  logic              first,
   output logic              same_sector,
   output logic              same_page,
   output logic              order_ok
);
   logic [OFF_W-1:0] off;
   logic             at_start;
   logic             succ_ok;

   assign off         = addr[OFF_W-1:0];
   assign same_sector = (addr[ADDR_W-1:SECT_LSB] == start_addr[ADDR_W-1:SECT_LSB]);
   assign same_page   = (addr[ADDR_W-1:OFF_W] == start_addr[ADDR_W-1:OFF_W]);
   assign at_start    = (addr == start_addr);

   // Ordering rule variant: gaps allowed (strictly ascending) or consecutive only
   generate
      if (GAPS_OK) begin : g_gaps
         assign succ_ok = (off > last_off);
      end else begin : g_dense
         assign succ_ok = ({1'b0, off} == ({1'b0, last_off} + 1'b1));
      end
   endgenerate

   assign order_ok = first ? at_start : succ_ok;
endmodule

// File: rtl/wbl_page_store.sv
module wbl_page_store #(
   parameter int PAGE_WORDS = 32,
   parameter int DATA_W     = 16,
   localparam int OFF_W     = $clog2(PAGE_WORDS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         we,
   input  logic [OFF_W-1:0]             woff,
   input  logic [DATA_W-1:0]            wdata,
   output logic [PAGE_WORDS*DATA_W-1:0] data_flat,
   output logic [PAGE_WORDS-1:0]        mask
);
   generate
      for (genvar k = 0; k < PAGE_WORDS; k++) begin : g_word
         logic [DATA_W-1:0] word_q;
         logic              hit;
         assign hit = we && (woff == OFF_W'(k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q  <= '0;
               mask[k] <= 1'b0;
            end else if (clear) begin
               word_q  <= '0;
               mask[k] <= 1'b0;
            end else if (hit) begin
               word_q  <= wdata;
               mask[k] <= 1'b1;
            end
         end
         assign data_flat[k*DATA_W +: DATA_W] = word_q;
      end
   endgenerate
endmodule

// File: rtl/wbl_ctrl.sv
module wbl_ctrl
   import wbl_pkg::*;
#(
   parameter int              ADDR_W     = 24,
   parameter int              DATA_W     = 16,
   parameter int              PAGE_WORDS = 32,
   parameter int              CODE_W     = 8,
   parameter logic [CODE_W-1:0] CMD_LOAD = 8'h3C,
   parameter logic [CODE_W-1:0] CMD_CONF = 8'hC3,
   localparam int             OFF_W      = $clog2(PAGE_WORDS),
   localparam int             CNT_W      = OFF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              same_sector,
   input  logic              same_page,
   input  logic              order_ok,
   output logic [ADDR_W-1:0] start_addr,
   output logic [OFF_W-1:0]  last_off,
   output logic              first,
   output logic              store_we,
   output logic              buf_clear,
   output logic              prog_req,
   output logic              load_abort
);
   wbl_state_e       state;
   logic [CNT_W-1:0] remain;
   logic             is_load;
   logic             is_conf;
   logic             cnt_bad;

   always_comb begin
      is_load   = (wr_data[CODE_W-1:0] == CMD_LOAD);
      is_conf   = (wr_data[CODE_W-1:0] == CMD_CONF);
      cnt_bad   = (wr_data > DATA_W'(PAGE_WORDS - 1));
      buf_clear = wr_en && (state == ST_IDLE) && is_load;
      store_we  = wr_en && (state == ST_DATA) && same_page && order_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         start_addr <= '0;
         last_off   <= '0;
         first      <= 1'b0;
         remain     <= '0;
         prog_req   <= 1'b0;
         load_abort <= 1'b0;
      end else begin
         prog_req <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (buf_clear) begin
                  start_addr <= wr_addr;
                  state      <= ST_COUNT;
               end
            end
            ST_COUNT: begin
               if (wr_en) begin
                  if (!same_sector || cnt_bad) begin
                     load_abort <= 1'b1;
                     state      <= ST_ABORT;
                  end else begin
                     remain <= CNT_W'(wr_data[OFF_W-1:0]) + 1'b1;
                     first  <= 1'b1;
                     state  <= ST_DATA;
                  end
               end
            end
            ST_DATA: begin
               if (wr_en) begin
                  if (store_we) begin
                     last_off <= wr_addr[OFF_W-1:0];
                     first    <= 1'b0;
                     remain   <= remain - 1'b1;
                     if (remain == CNT_W'(1)) state <= ST_CONFIRM;
                  end else begin
                     load_abort <= 1'b1;
                     state      <= ST_ABORT;
                  end
               end
            end
            ST_CONFIRM: begin
               if (wr_en) begin
                  if (is_conf && same_sector) begin
                     prog_req <= 1'b1;
                     state    <= ST_IDLE;
                  end else begin
                     load_abort <= 1'b1;
                     state      <= ST_ABORT;
                  end
               end
            end
            default: begin
               load_abort <= 1'b1;
               state      <= ST_ABORT;
            end
         endcase
      end
   end
endmodule

// File: rtl/flash_wrbuf_loader.sv
module flash_wrbuf_loader #(
   parameter int                ADDR_W     = 24,
   parameter int                DATA_W     = 16,
   parameter int                PAGE_WORDS = 32,
   parameter int                SECT_LSB   = 16,
   parameter int                CODE_W     = 8,
   parameter logic [CODE_W-1:0] CMD_LOAD   = 8'h3C,
   parameter logic [CODE_W-1:0] CMD_CONF   = 8'hC3,
   parameter bit                GAPS_OK    = 1'b1,
   localparam int               OFF_W      = $clog2(PAGE_WORDS),
   localparam int               PAGE_W     = ADDR_W - OFF_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   output logic                         prog_req,
   output logic [PAGE_W-1:0]            prog_page,
   output logic [PAGE_WORDS-1:0]        prog_mask,
   output logic [PAGE_WORDS*DATA_W-1:0] prog_data,
   output logic                         load_abort
);
   generate
      if (PAGE_WORDS != (1 << OFF_W) || PAGE_WORDS < 2) begin : g_bad_page
         $error("PAGE_WORDS must be a power of two, at least 2");
      end
      if (SECT_LSB < OFF_W || SECT_LSB >= ADDR_W) begin : g_bad_sector
         $error("SECT_LSB must lie between the page offset and the address MSB");
      end
      if (DATA_W < CODE_W || DATA_W <= OFF_W) begin : g_bad_data
         $error("DATA_W too narrow for command codes or word count");
      end
   endgenerate

   logic [ADDR_W-1:0] start_addr;
   logic [OFF_W-1:0]  last_off;
   logic              first;
   logic              same_sector;
   logic              same_page;
   logic              order_ok;
   logic              store_we;
   logic              buf_clear;

   wbl_addr_check #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SECT_LSB(SECT_LSB), .GAPS_OK(GAPS_OK)
   ) u_chk_addr (
      .addr(wr_addr), .start_addr(start_addr), .last_off(last_off), .first(first),
      .same_sector(same_sector), .same_page(same_page), .order_ok(order_ok)
   );

   wbl_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS), .CODE_W(CODE_W),
      .CMD_LOAD(CMD_LOAD), .CMD_CONF(CMD_CONF)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .same_sector(same_sector), .same_page(same_page), .order_ok(order_ok),
      .start_addr(start_addr), .last_off(last_off), .first(first),
      .store_we(store_we), .buf_clear(buf_clear),
      .prog_req(prog_req), .load_abort(load_abort)
   );

   wbl_page_store #(
      .PAGE_WORDS(PAGE_WORDS), .DATA_W(DATA_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .clear(buf_clear), .we(store_we),
      .woff(wr_addr[OFF_W-1:0]), .wdata(wr_data),
      .data_flat(prog_data), .mask(prog_mask)
   );

   assign prog_page = start_addr[ADDR_W-1:OFF_W];
endmodule

// File: rtl/wbl_checker.sv
module wbl_checker #(
   parameter int                DATA_W     = 16,
   parameter int                PAGE_WORDS = 32,
   parameter int                CODE_W     = 8,
   parameter logic [CODE_W-1:0] CMD_CONF   = 8'hC3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [DATA_W-1:0]     wr_data,
   input logic                  prog_req,
   input logic [PAGE_WORDS-1:0] prog_mask,
   input logic                  load_abort
);
   // R1: outputs quiet while reset is held
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!prog_req && !load_abort));

   // R2: request is a single-cycle pulse
   p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> !prog_req);

   // R2, R8: request only follows a confirm-code write
   p_req_after_conf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_req) |-> ($past(wr_en) && ($past(wr_data[CODE_W-1:0]) == CMD_CONF)));

   // R3: a request always carries at least one loaded word
   p_mask_present_r3: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> (prog_mask != '0));

   // R9: abort is sticky
   p_abort_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_abort |=> load_abort);

   // R9: no request once aborted
   p_no_req_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_abort |-> !prog_req);
endmodule

bind flash_wrbuf_loader wbl_checker #(
   .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS), .CODE_W(CODE_W), .CMD_CONF(CMD_CONF)
) u_wbl_checker (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .prog_req(prog_req), .prog_mask(prog_mask), .load_abort(load_abort)
);

// File: tb/sim_flash_wrbuf_loader.sv
`timescale 1ns/1ps
module sim_flash_wrbuf_loader;
   localparam int AW = 24;
   localparam int DW = 16;
   localparam int PW = 32;
   localparam logic [DW-1:0] LOADC = 16'h003C;
   localparam logic [DW-1:0] CONFC = 16'h00C3;
   localparam logic [AW-1:0] PBASE = 24'h012340;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [DW-1:0]   wr_data = '0;
   logic            prog_req;
   logic [AW-6:0]   prog_page;
   logic [PW-1:0]   prog_mask;
   logic [PW*DW-1:0] prog_data;
   logic            load_abort;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   flash_wrbuf_loader u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .prog_req(prog_req), .prog_page(prog_page), .prog_mask(prog_mask),
      .prog_data(prog_data), .load_abort(load_abort)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] word_at(input int k);
      return prog_data[k*DW +: DW];
   endfunction

   // one write; returns 1 time unit after the accepting edge
   task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      wr_en = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 prog_req", 64'(prog_req), 64'd0);
      chk("R1 load_abort", 64'(load_abort), 64'd0);
      chk("R1 prog_mask", 64'(prog_mask), 64'd0);
   endtask

   task automatic t_full_page();
      do_reset();
      put(PBASE, LOADC);
      put(PBASE, 16'd31);
      for (int i = 0; i < 32; i++) put(PBASE + 24'(i), 16'hA000 + 16'(i));
      chk("R2 no req before confirm", 64'(prog_req), 64'd0);
      put(PBASE + 24'd3, CONFC);
      chk("R2 req", 64'(prog_req), 64'd1);
      chk("R2 page", 64'(prog_page), 64'(PBASE >> 5));
      chk("R2 word0", 64'(word_at(0)), 64'hA000);
      chk("R2 word31", 64'(word_at(31)), 64'hA01F);
      chk("R3 full mask", 64'(prog_mask), 64'hFFFF_FFFF);
      @(posedge clk); #1;
      chk("R2 single pulse", 64'(prog_req), 64'd0);
   endtask

   task automatic t_gaps();
      do_reset();
      put(PBASE + 24'd5, LOADC);
      put(PBASE + 24'd5, 16'd3);
      put(PBASE + 24'd5, 16'h1111);
      put(PBASE + 24'd7, 16'h2222);
      put(PBASE + 24'd8, 16'h3333);
      put(PBASE + 24'd20, 16'h4444);
      put(PBASE, CONFC);
      chk("R4 req mid start", 64'(prog_req), 64'd1);
      chk("R3 gap mask", 64'(prog_mask), 64'h0010_01A0);
      chk("R3 word7", 64'(word_at(7)), 64'h2222);
      chk("R3 word20", 64'(word_at(20)), 64'h4444);
      chk("R3 unloaded word6", 64'(word_at(6)), 64'h0);
      chk("R4 abort clear", 64'(load_abort), 64'd0);
   endtask

   task automatic t_single_last();
      do_reset();
      put(PBASE + 24'd31, LOADC);
      put(PBASE + 24'd31, 16'd0);
      put(PBASE + 24'd31, 16'hBEEF);
      put(PBASE + 24'd31, CONFC);
      chk("R2 one word req", 64'(prog_req), 64'd1);
      chk("R3 one word mask", 64'(prog_mask), 64'h8000_0000);
      chk("R2 one word data", 64'(word_at(31)), 64'hBEEF);
   endtask

   task automatic t_bad_first();
      do_reset();
      put(PBASE + 24'd8, LOADC);
      put(PBASE + 24'd8, 16'd1);
      chk("R4 no abort yet", 64'(load_abort), 64'd0);
      put(PBASE + 24'd9, 16'h5555);
      chk("R4 first not at start", 64'(load_abort), 64'd1);
   endtask

   task automatic t_descend();
      do_reset();
      put(PBASE + 24'd4, LOADC);
      put(PBASE + 24'd4, 16'd2);
      put(PBASE + 24'd4, 16'h0001);
      put(PBASE + 24'd6, 16'h0002);
      chk("R5 ascending ok", 64'(load_abort), 64'd0);
      put(PBASE + 24'd6, 16'h0003);
      chk("R5 repeat offset", 64'(load_abort), 64'd1);
   endtask

   task automatic t_page_sector();
      do_reset();
      put(PBASE + 24'd30, LOADC);
      put(PBASE + 24'd30, 16'd2);
      put(PBASE + 24'd30, 16'h0001);
      put(PBASE + 24'd31, 16'h0002);
      put(PBASE + 24'd32, 16'h0003);
      chk("R6 next page", 64'(load_abort), 64'd1);
      do_reset();
      put(PBASE, LOADC);
      put(PBASE + 24'h010000, 16'd0);
      chk("R6 count other sector", 64'(load_abort), 64'd1);
      do_reset();
      put(PBASE, LOADC);
      put(PBASE, 16'd0);
      put(PBASE, 16'h7777);
      put(PBASE + 24'h010000, CONFC);
      chk("R6 confirm other sector", 64'(load_abort), 64'd1);
      chk("R6 no req", 64'(prog_req), 64'd0);
   endtask

   task automatic t_count();
      do_reset();
      put(PBASE, LOADC);
      put(PBASE, 16'd32);
      chk("R7 count 32", 64'(load_abort), 64'd1);
   endtask

   task automatic t_confirm();
      do_reset();
      put(PBASE, LOADC);
      put(PBASE, 16'd0);
      put(PBASE, 16'h1234);
      put(PBASE + 24'd1, 16'h5678);
      chk("R8 extra word aborts", 64'(load_abort), 64'd1);
      chk("R8 no req", 64'(prog_req), 64'd0);
   endtask

   task automatic t_sticky();
      do_reset();
      put(PBASE, LOADC);
      put(PBASE, 16'd40);
      put(PBASE, LOADC);
      put(PBASE, 16'd0);
      put(PBASE, 16'h9999);
      put(PBASE, CONFC);
      chk("R9 no req after abort", 64'(prog_req), 64'd0);
      chk("R9 abort held", 64'(load_abort), 64'd1);
      chk("R9 mask untouched", 64'(prog_mask), 64'd0);
      do_reset();
      chk("R9 reset clears", 64'(load_abort), 64'd0);
   endtask

   task automatic t_idle_ignore();
      do_reset();
      put(PBASE, CONFC);
      chk("R10 confirm in idle", 64'(prog_req), 64'd0);
      put(PBASE, 16'h3C3D);
      put(PBASE + 24'd2, 16'h00FF);
      chk("R10 idle abort", 64'(load_abort), 64'd0);
      put(PBASE + 24'd2, 16'h113C);
      put(PBASE + 24'd2, 16'd0);
      put(PBASE + 24'd2, 16'hCAFE);
      put(PBASE + 24'd2, CONFC);
      chk("R10 later sequence", 64'(prog_req), 64'd1);
      chk("R10 later mask", 64'(prog_mask), 64'h0000_0004);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_full_page();
      t_gaps();
      t_single_last();
      t_bad_first();
      t_descend();
      t_page_sector();
      t_count();
      t_confirm();
      t_sticky();
      t_idle_ignore();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule